// File: doc/BRIEF.md
# Two-Clock Synchronous Dual-Port Memory

This block is a synthesizable two-port static memory of 4096 words, each 9 bits wide. Either port can reach any word at any time, and each port runs on its own clock with no relation assumed between the two. The ninth bit of each word is stored like the other eight, so a system can use it as a parity bit if it wants one.

Each port registers its select, direction, address and write data on the rising edge of its clock. A write sampled on one edge is committed into the array by the next edge. A read sampled on one edge loads the read data on the next edge. The data then holds until that port captures another read.

A per-port hold input freezes the address and write-data registers, so a stalled port repeats its last address. An active-low select deselects the port for whole cycles. An active-low output enable gates the valid flag directly, with no clock involved. The three-state bus is modelled as a data vector plus a valid flag.

Top module: `dpram_dual`

## Requirements
- R1: Each of the two ports has its own independent clock and can access any of the 4096 words. A word written through one port reads back, all 9 bits, through either port.
- R2: A read is captured on the edge that samples select low and direction high (`x_rd_wr_n` = 1). The read data and the valid flag appear after the following edge of the same port's clock. After the capturing edge alone, the valid flag still shows the earlier cycle.
- R3: An edge that samples select low and direction low captures a write. The captured data is stored at the captured address by the next edge of that port. After a write cycle the port's valid flag is low.
- R4: While `x_hold` is high at an edge, the address and write-data registers keep their earlier contents. A read then returns the word at the held address, and a write stores the held data at the held address.
- R5: An edge that samples `x_sel_n` high deselects the port. It writes nothing, and the valid flag is low after the following edge whatever `x_oe_n` is.
- R6: The valid flag equals "the last captured cycle was a selected read" AND `x_oe_n` low. A change of `x_oe_n` takes effect with no clock edge and leaves `x_rdata` unchanged.
- R7: `x_rdata` keeps its value through write, deselected and output-disabled cycles until the port captures its next read.
- R8: When one port writes a word that the other port is reading, the reader may return old or new data on the overlapping cycle. A read of that word started after the write has committed returns the new value.
- R9: When both ports write the same word, the stored value is the one whose write committed last.
- R10: While a port's reset is high, that port's valid flag is low and no write is committed. After reset its captured cycle is a deselected one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A synchronous reset, active high |
| a_sel_n | input | 1 | Port A select, active low |
| a_rd_wr_n | input | 1 | Port A direction: 1 read, 0 write |
| a_hold | input | 1 | Port A hold of address and data registers, active high |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_rvalid | output | 1 | Port A read data valid (bus driven) |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B synchronous reset, active high |
| b_sel_n | input | 1 | Port B select, active low |
| b_rd_wr_n | input | 1 | Port B direction: 1 read, 0 write |
| b_hold | input | 1 | Port B hold of address and data registers, active high |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | 1 | Port B read data valid (bus driven) |

## Verification
Timing is counted in edges of the operating port's clock. A captured read shows its data and valid flag one edge after the capturing edge. A captured write is in the array one edge after capture. A change of output enable shows on the valid flag a nanosecond later, with no edge. The bench drives inputs on falling edges and samples outputs on falling edges. It waits out exactly two rising edges after a read or write request before checking data. For the latency, output-enable and deselect checks it samples after the first edge as well, to confirm that nothing has appeared early.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Kind of cycle a port captured on its last rising edge.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  function automatic cyc_e decode_cycle(input logic sel_n, input logic rd_wr_n);
    if (sel_n)        return CYC_IDLE;
    else if (rd_wr_n) return CYC_READ;
    else              return CYC_WRITE;
  endfunction

endpackage

// File: rtl/dpram_port_capture.sv
module dpram_port_capture
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              rd_wr_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cyc_e              cyc,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);

  // Control is captured every edge; address and data only when not held.
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= CYC_IDLE;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      cyc <= decode_cycle(sel_n, rd_wr_n);
      if (!hold) begin
        cap_addr <= addr;
        cap_data <= wdata;
      end
    end
  end

endmodule

// File: rtl/dpram_bank.sv
// One storage bank owned by a single writing port, with a registered read
// tap per port clock and a tag bit per word used to pick the newest bank.
module dpram_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9,
  parameter int TAPS   = 2
) (
  input  logic                         wclk,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         wflag,
  input  logic [ADDR_W-1:0]            peek_addr,
  output logic                         peek_flag,
  input  logic [TAPS-1:0]              rclk,
  input  logic [TAPS-1:0]              rrst,
  input  logic [TAPS-1:0]              ren,
  input  logic [TAPS-1:0][ADDR_W-1:0]  raddr,
  output logic [TAPS-1:0][DATA_W-1:0]  rdata,
  output logic [TAPS-1:0]              rflag
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              tag [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
      tag[waddr] <= wflag;
    end
  end

  assign peek_flag = tag[peek_addr];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    logic [DATA_W-1:0] q_d;
    logic              q_f;

    always_ff @(posedge rclk[g]) begin
      if (rrst[g]) begin
        q_d <= '0;
        q_f <= 1'b0;
      end else if (ren[g]) begin
        q_d <= mem[raddr[g]];
        q_f <= tag[raddr[g]];
      end
    end

    assign rdata[g] = q_d;
    assign rflag[g] = q_f;
  end

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
  import dpram_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] d_a,
  input  logic [DATA_W-1:0] d_b,
  input  logic              f_a,
  input  logic              f_b,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic rd_live;

  always_ff @(posedge clk) begin
    if (rst) rd_live <= 1'b0;
    else     rd_live <= (cyc == CYC_READ);
  end

  // Tags differ: bank A holds the newest write of this word.
  assign rdata  = (f_a ^ f_b) ? d_a : d_b;
  assign rvalid = rd_live & ~oe_n;

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              a_clk,
  input  logic              a_rst,
  input  logic              a_sel_n,
  input  logic              a_rd_wr_n,
  input  logic              a_hold,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_clk,
  input  logic              b_rst,
  input  logic              b_sel_n,
  input  logic              b_rd_wr_n,
  input  logic              b_hold,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);

  localparam int PORTS = 2;

  logic [PORTS-1:0]             clk_v, rst_v, sel_v, rw_v, hold_v, oe_v, ren_v;
  logic [PORTS-1:0][ADDR_W-1:0] addr_v, raddr_v;
  logic [PORTS-1:0][DATA_W-1:0] data_v;

  cyc_e              cyc_q    [PORTS];
  logic [ADDR_W-1:0] cap_addr [PORTS];
  logic [DATA_W-1:0] cap_data [PORTS];
  logic              peek_v   [PORTS];
  logic              wflag_v  [PORTS];
  logic [PORTS-1:0][DATA_W-1:0] tap_d [PORTS];
  logic [PORTS-1:0]             tap_f [PORTS];
  logic [DATA_W-1:0] rd_v [PORTS];
  logic              rv_v [PORTS];

  assign clk_v  = {b_clk, a_clk};
  assign rst_v  = {b_rst, a_rst};
  assign sel_v  = {b_sel_n, a_sel_n};
  assign rw_v   = {b_rd_wr_n, a_rd_wr_n};
  assign hold_v = {b_hold, a_hold};
  assign oe_v   = {b_oe_n, a_oe_n};
  assign addr_v = {b_addr, a_addr};
  assign data_v = {b_wdata, a_wdata};

  // Port A makes the tags differ, port B makes them equal.
  assign wflag_v[0] = ~peek_v[1];
  assign wflag_v[1] = peek_v[0];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpram_port_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk      (clk_v[p]),
      .rst      (rst_v[p]),
      .sel_n    (sel_v[p]),
      .rd_wr_n  (rw_v[p]),
      .hold     (hold_v[p]),
      .addr     (addr_v[p]),
      .wdata    (data_v[p]),
      .cyc      (cyc_q[p]),
      .cap_addr (cap_addr[p]),
      .cap_data (cap_data[p])
    );

    assign ren_v[p]   = (cyc_q[p] == CYC_READ);
    assign raddr_v[p] = cap_addr[p];

    dpram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAPS(PORTS)) u_bank (
      .wclk      (clk_v[p]),
      .we        (cyc_q[p] == CYC_WRITE),
      .waddr     (cap_addr[p]),
      .wdata     (cap_data[p]),
      .wflag     (wflag_v[p]),
      .peek_addr (cap_addr[PORTS-1-p]),
      .peek_flag (peek_v[p]),
      .rclk      (clk_v),
      .rrst      (rst_v),
      .ren       (ren_v),
      .raddr     (raddr_v),
      .rdata     (tap_d[p]),
      .rflag     (tap_f[p])
    );

    dpram_port_out #(.DATA_W(DATA_W)) u_out (
      .clk    (clk_v[p]),
      .rst    (rst_v[p]),
      .cyc    (cyc_q[p]),
      .oe_n   (oe_v[p]),
      .d_a    (tap_d[0][p]),
      .d_b    (tap_d[1][p]),
      .f_a    (tap_f[0][p]),
      .f_b    (tap_f[1][p]),
      .rdata  (rd_v[p]),
      .rvalid (rv_v[p])
    );
  end

  assign a_rdata  = rd_v[0];
  assign a_rvalid = rv_v[0];
  assign b_rdata  = rd_v[1];
  assign b_rvalid = rv_v[1];

endmodule

// File: rtl/dpram_dual_check.sv
module dpram_dual_check #(
  parameter int DATA_W = 9
) (
  input logic              a_clk,
  input logic              a_rst,
  input logic              a_sel_n,
  input logic              a_rd_wr_n,
  input logic              a_oe_n,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_rvalid,
  input logic              b_clk,
  input logic              b_rst,
  input logic              b_sel_n,
  input logic              b_rd_wr_n,
  input logic              b_oe_n,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_rvalid
);

  assert_rd_due_a_R2: assert property (@(posedge a_clk) disable iff (a_rst)
    (!a_sel_n && a_rd_wr_n) |=> ##1 (a_rvalid || a_oe_n));
  assert_rd_due_b_R2: assert property (@(posedge b_clk) disable iff (b_rst)
    (!b_sel_n && b_rd_wr_n) |=> ##1 (b_rvalid || b_oe_n));

  assert_wr_quiet_a_R3: assert property (@(posedge a_clk) disable iff (a_rst)
    (!a_sel_n && !a_rd_wr_n) |=> ##1 !a_rvalid);
  assert_wr_quiet_b_R3: assert property (@(posedge b_clk) disable iff (b_rst)
    (!b_sel_n && !b_rd_wr_n) |=> ##1 !b_rvalid);

  assert_dsel_quiet_a_R5: assert property (@(posedge a_clk) disable iff (a_rst)
    a_sel_n |=> ##1 !a_rvalid);
  assert_dsel_quiet_b_R5: assert property (@(posedge b_clk) disable iff (b_rst)
    b_sel_n |=> ##1 !b_rvalid);

  assert_oe_gate_a_R6: assert property (@(posedge a_clk) disable iff (a_rst)
    a_rvalid |-> !a_oe_n);
  assert_oe_gate_b_R6: assert property (@(posedge b_clk) disable iff (b_rst)
    b_rvalid |-> !b_oe_n);

  assert_data_hold_a_R7: assert property (@(posedge a_clk) disable iff (a_rst)
    !(!a_sel_n && a_rd_wr_n) |=> ##1 $stable(a_rdata));
  assert_data_hold_b_R7: assert property (@(posedge b_clk) disable iff (b_rst)
    !(!b_sel_n && b_rd_wr_n) |=> ##1 $stable(b_rdata));

endmodule

bind dpram_dual dpram_dual_check #(.DATA_W(DATA_W)) i_chk (
  .a_clk     (a_clk),
  .a_rst     (a_rst),
  .a_sel_n   (a_sel_n),
  .a_rd_wr_n (a_rd_wr_n),
  .a_oe_n    (a_oe_n),
  .a_rdata   (a_rdata),
  .a_rvalid  (a_rvalid),
  .b_clk     (b_clk),
  .b_rst     (b_rst),
  .b_sel_n   (b_sel_n),
  .b_rd_wr_n (b_rd_wr_n),
  .b_oe_n    (b_oe_n),
  .b_rdata   (b_rdata),
  .b_rvalid  (b_rvalid)
);

// File: tb/test_dpram_dual.sv
module test_dpram_dual;

  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = CLK_PERIOD + 4;
  localparam int AW = 12;
  localparam int DW = 9;
  localparam int NV = 10;

  // Vector: [22] port (0 A, 1 B), [21] write, [20:9] address, [8:0] data.
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b1, 12'h000, 9'h1A5},
    {1'b1, 1'b1, 12'hFFF, 9'h0FF},
    {1'b0, 1'b1, 12'h555, 9'h100},
    {1'b1, 1'b0, 12'h000, 9'h1A5},
    {1'b0, 1'b0, 12'hFFF, 9'h0FF},
    {1'b1, 1'b0, 12'h555, 9'h100},
    {1'b1, 1'b1, 12'h555, 9'h0AA},
    {1'b0, 1'b0, 12'h555, 9'h0AA},
    {1'b0, 1'b1, 12'h001, 9'h1FF},
    {1'b1, 1'b0, 12'h001, 9'h1FF}
  };

  logic a_clk = 0, b_clk = 0;
  logic a_rst = 1, b_rst = 1;
  logic a_sel_n = 1, a_rd_wr_n = 1, a_hold = 0, a_oe_n = 0;
  logic b_sel_n = 1, b_rd_wr_n = 1, b_hold = 0, b_oe_n = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD / 2) a_clk = ~a_clk;
  always #(CLK_B_PERIOD / 2) b_clk = ~b_clk;

  dpram_dual #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_dual (
    .a_clk(a_clk), .a_rst(a_rst), .a_sel_n(a_sel_n), .a_rd_wr_n(a_rd_wr_n),
    .a_hold(a_hold), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_clk(b_clk), .b_rst(b_rst), .b_sel_n(b_sel_n), .b_rd_wr_n(b_rd_wr_n),
    .b_hold(b_hold), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  task automatic check(input bit ok, input string tag, input logic [DW:0] act,
                       input logic [DW:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual={valid,data}=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int p);
    if (p == 0) @(negedge a_clk);
    else        @(negedge b_clk);
  endtask

  task automatic set_port(input int p, input logic sel_n, input logic rw,
                          input logic hold, input logic [AW-1:0] addr,
                          input logic [DW-1:0] data);
    if (p == 0) begin
      a_sel_n = sel_n; a_rd_wr_n = rw; a_hold = hold; a_addr = addr; a_wdata = data;
    end else begin
      b_sel_n = sel_n; b_rd_wr_n = rw; b_hold = hold; b_addr = addr; b_wdata = data;
    end
  endtask

  task automatic idle(input int p);
    set_port(p, 1'b1, 1'b1, 1'b0, '0, '0);
  endtask

  function automatic logic [DW:0] outs(input int p);
    return (p == 0) ? {a_rvalid, a_rdata} : {b_rvalid, b_rdata};
  endfunction

  task automatic do_write(input int p, input logic [AW-1:0] addr,
                          input logic [DW-1:0] data);
    tick(p);
    set_port(p, 1'b0, 1'b0, 1'b0, addr, data);
    tick(p);
    idle(p);
    tick(p);
  endtask

  task automatic do_read(input int p, input logic [AW-1:0] addr,
                         input logic [DW-1:0] exp, input bit chk, input string tag);
    tick(p);
    set_port(p, 1'b0, 1'b1, 1'b0, addr, '0);
    tick(p);
    idle(p);
    tick(p);
    if (chk) check(outs(p) == {1'b1, exp}, tag, outs(p), {1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge a_clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R10: reset with outputs enabled keeps both valid flags low.
    repeat (3) tick(0);
    check(outs(0) == {1'b0, 9'h000}, "R10 port A after reset", outs(0), {1'b0, 9'h000});
    check(b_rvalid == 1'b0, "R10 port B after reset", outs(1), {1'b0, b_rdata});
    tick(0); a_rst = 0;
    tick(1); b_rst = 0;

    // R1 / R3: vector table walked across both ports.
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) do_write(int'(VEC[i][22]), VEC[i][20:9], VEC[i][8:0]);
      else do_read(int'(VEC[i][22]), VEC[i][20:9], VEC[i][8:0], 1'b1,
                   $sformatf("R1 R3 vector %0d", i));
    end

    // R2: valid not yet after the capturing edge, present after the next.
    tick(0);
    set_port(0, 1'b0, 1'b1, 1'b0, 12'h000, '0);
    tick(0);
    check(a_rvalid == 1'b0, "R2 early edge", outs(0), {1'b0, a_rdata});
    idle(0);
    tick(0);
    check(outs(0) == {1'b1, 9'h1A5}, "R2 due edge", outs(0), {1'b1, 9'h1A5});

    // R6: output enable acts without a clock edge.
    a_oe_n = 1; #1;
    check(outs(0) == {1'b0, 9'h1A5}, "R6 oe off", outs(0), {1'b0, 9'h1A5});
    a_oe_n = 0; #1;
    check(outs(0) == {1'b1, 9'h1A5}, "R6 oe on", outs(0), {1'b1, 9'h1A5});

    // R7 / R3: data holds through a write and idle cycles, valid drops.
    do_write(0, 12'h002, 9'h077);
    check(outs(0) == {1'b0, 9'h1A5}, "R7 R3 after write", outs(0), {1'b0, 9'h1A5});
    repeat (3) tick(0);
    check(a_rdata == 9'h1A5, "R7 after idle", outs(0), {1'b0, 9'h1A5});

    // R5: deselected write request stores nothing.
    tick(0);
    set_port(0, 1'b1, 1'b0, 1'b0, 12'h000, 9'h111);
    tick(0);
    idle(0);
    tick(0);
    check(a_rvalid == 1'b0, "R5 deselect valid", outs(0), {1'b0, a_rdata});
    do_read(0, 12'h000, 9'h1A5, 1'b1, "R5 no write");

    // R4: held address for a read, held address and data for a write.
    do_write(0, 12'h020, 9'h000);
    tick(0);
    set_port(0, 1'b0, 1'b1, 1'b0, 12'hFFF, '0);
    tick(0);
    set_port(0, 1'b0, 1'b1, 1'b1, 12'h000, '0);
    tick(0);
    idle(0);
    tick(0);
    check(outs(0) == {1'b1, 9'h0FF}, "R4 held read", outs(0), {1'b1, 9'h0FF});
    tick(0);
    set_port(0, 1'b1, 1'b1, 1'b0, 12'h010, 9'h033);
    tick(0);
    set_port(0, 1'b0, 1'b0, 1'b1, 12'h020, 9'h044);
    tick(0);
    idle(0);
    tick(0);
    do_read(0, 12'h010, 9'h033, 1'b1, "R4 held write target");
    do_read(0, 12'h020, 9'h000, 1'b1, "R4 held write untouched");

    // R8: B reads a word while A writes it; a later B read sees the new data.
    do_write(1, 12'h300, 9'h03C);
    fork
      do_write(0, 12'h300, 9'h0C3);
      for (int k = 0; k < 3; k++) do_read(1, 12'h300, '0, 1'b0, "");
    join
    do_read(1, 12'h300, 9'h0C3, 1'b1, "R8 later read");

    // R9: last committed write wins, in either order.
    do_write(0, 12'h400, 9'h011);
    do_write(1, 12'h400, 9'h122);
    do_read(0, 12'h400, 9'h122, 1'b1, "R9 B last");
    do_write(0, 12'h400, 9'h133);
    do_read(1, 12'h400, 9'h133, 1'b1, "R9 A last");

    // R10: a write requested while in reset is not committed.
    do_write(0, 12'h007, 9'h055);
    tick(0);
    a_rst = 1;
    set_port(0, 1'b0, 1'b0, 1'b0, 12'h007, 9'h1EE);
    repeat (3) tick(0);
    check(a_rvalid == 1'b0, "R10 in reset", outs(0), {1'b0, a_rdata});
    idle(0);
    a_rst = 0;
    repeat (2) tick(0);
    do_read(0, 12'h007, 9'h055, 1'b1, "R10 no write in reset");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule